// File: doc/BRIEF.md
# Vector Compare to Predicate Generator

This block runs a compare-and-branch instruction over a vector of register-file elements and produces a predicate bitfield. Each of the two source operands is classified on its own. A source whose vector length is more than one is a vector and steps through consecutive registers. Any other source is a scalar and reads the same register for every element. The block compares one element per cycle, sets bit i of an accumulator to the outcome for element i, and then writes the finished word to a target integer register through a single write port.

When both sources are scalar, the block builds no predicate. It reads the two registers once and reports an ordinary branch decision, taken or not taken, on a separate strobe. A new operation is accepted only while the block is idle. The register file is external and is read through two combinational read ports.

Top module: `vec_cmp_pred`

## Requirements
- R1: A source is a vector when its length input is greater than 1. A length of 0 or 1 makes it a scalar.
- R2: For element i, a vector source reads register (src + i) modulo the register count, and a scalar source reads register src.
- R3: Bit i of the written predicate, for i < VL, equals the compare result of element i. Bits at or above VL are zero. A VL above XLEN is treated as XLEN.
- R4: cmpSel encodes the compare of A against B: 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, 4 unsigned less-than, 5 unsigned greater-or-equal. Codes 6 and 7 always give false.
- R5: When at least one source is a vector, the predicate is written as a one-cycle pulse on wrEn. The pulse carries wrAddr equal to the target register given at start and comes together with a one-cycle done pulse.
- R6: When both sources are scalar, wrEn stays low. brValid and done pulse for one cycle, with brTaken equal to the compare result on registers srcA and srcB.
- R7: For a predicate operation, done rises max(VL,1) clock edges after the edge that samples start, and a VL of 0 writes an all-zero word. A branch operation raises done one edge after start.
- R8: busy is high from the edge after an accepted start until the edge that raises done. A start while busy is ignored: it does not change the result of the running operation and does not produce a second done.
- R9: After reset, busy, done, wrEn and brValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| srcA | input | 5 | First source register number |
| lenA | input | 6 | Vector length of the first source |
| srcB | input | 5 | Second source register number |
| lenB | input | 6 | Vector length of the second source |
| vl | input | 6 | Global element count |
| cmpSel | input | 3 | Compare type |
| predReg | input | 5 | Target register for the predicate |
| rdAddrA | output | 5 | Register-file read address, operand A |
| rdDataA | input | 32 | Register-file read data, operand A |
| rdAddrB | output | 5 | Register-file read address, operand B |
| rdDataB | input | 32 | Register-file read data, operand B |
| busy | output | 1 | Operation in progress |
| wrEn | output | 1 | Predicate write strobe |
| wrAddr | output | 5 | Predicate write register |
| wrData | output | 32 | Predicate word |
| brValid | output | 1 | Branch decision strobe |
| brTaken | output | 1 | Branch decision |
| done | output | 1 | Operation complete |

## Verification
Random operations mix vector-vector, vector-scalar, scalar-vector and scalar-scalar operand pairs over all eight compare codes. The register contents are drawn from a narrow value range, which makes equal and near-equal pairs common. This separates the signed compares from the unsigned ones and shows that each operand's register index steps, or stays put, on its own. Directed cases cover a VL of 0, a VL at and above the word width, source numbers that wrap past the last register, and lengths of exactly 1. A start issued mid-operation must leave the result and the done count unchanged. Every operation is also timed against the expected done cycle.

// File: rtl/vec_cmp_pred_pkg.sv
package vec_cmp_pred_pkg;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LT  = 3'd2,
    CMP_GE  = 3'd3,
    CMP_LTU = 3'd4,
    CMP_GEU = 3'd5
  } cmp_e;

  typedef struct packed {
    logic load;      // capture operation parameters, clear accumulator
    logic vecA;      // operand A steps per element
    logic vecB;      // operand B steps per element
    logic accumEn;   // fold this cycle's compare into the accumulator
    logic lastPred;  // final predicate cycle: issue the write
    logic lastBr;    // branch cycle: issue the decision
  } ctrl_t;

endpackage

// File: rtl/vec_cmp_pred_ctrl.sv
module vec_cmp_pred_ctrl
  import vec_cmp_pred_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int VLW  = $clog2(XLEN + 1),
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VLW-1:0]  lenA,
  input  logic [VLW-1:0]  lenB,
  input  logic [VLW-1:0]  vl,
  output ctrl_t           ctl,
  output logic [IDXW-1:0] idx,
  output logic            busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_BR} state_e;

  state_e         state;
  logic [VLW-1:0] vlQ;
  logic [VLW-1:0] vlClamp;
  logic           lastElem;

  assign vlClamp  = (vl > VLW'(XLEN)) ? VLW'(XLEN) : vl;
  assign lastElem = (vlQ == '0) || (VLW'(idx) == vlQ - VLW'(1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.vecA     = (lenA > VLW'(1));
    ctl.vecB     = (lenB > VLW'(1));
    ctl.load     = (state == ST_IDLE) && start;
    ctl.accumEn  = (state == ST_RUN) && (vlQ != '0);
    ctl.lastPred = (state == ST_RUN) && lastElem;
    ctl.lastBr   = (state == ST_BR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      vlQ   <= '0;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            vlQ   <= vlClamp;
            idx   <= '0;
            state <= (ctl.vecA || ctl.vecB) ? ST_RUN : ST_BR;
          end
        end
        ST_RUN: begin
          if (lastElem) state <= ST_IDLE;
          else          idx   <= idx + IDXW'(1);
        end
        ST_BR:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vec_cmp_pred_dpath.sv
module vec_cmp_pred_dpath
  import vec_cmp_pred_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int REGW = $clog2(NREG),
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctl,
  input  logic [IDXW-1:0] idx,
  input  logic [REGW-1:0] srcA,
  input  logic [REGW-1:0] srcB,
  input  logic [2:0]      cmpSel,
  input  logic [REGW-1:0] predReg,
  output logic [REGW-1:0] rdAddrA,
  input  logic [XLEN-1:0] rdDataA,
  output logic [REGW-1:0] rdAddrB,
  input  logic [XLEN-1:0] rdDataB,
  output logic            wrEn,
  output logic [REGW-1:0] wrAddr,
  output logic [XLEN-1:0] wrData,
  output logic            brValid,
  output logic            brTaken,
  output logic            done
);

  logic [REGW-1:0] srcAQ, srcBQ, predRegQ;
  logic            vecAQ, vecBQ;
  logic [2:0]      cmpQ;
  logic [XLEN-1:0] acc, accNext;
  logic            cmpRes;
  logic [REGW-1:0] stepIdx;

  assign stepIdx = REGW'(idx);
  assign rdAddrA = srcAQ + (vecAQ ? stepIdx : '0);
  assign rdAddrB = srcBQ + (vecBQ ? stepIdx : '0);

  always_comb begin
    unique case (cmpQ)
      CMP_EQ:  cmpRes = (rdDataA == rdDataB);
      CMP_NE:  cmpRes = (rdDataA != rdDataB);
      CMP_LT:  cmpRes = ($signed(rdDataA) <  $signed(rdDataB));
      CMP_GE:  cmpRes = ($signed(rdDataA) >= $signed(rdDataB));
      CMP_LTU: cmpRes = (rdDataA <  rdDataB);
      CMP_GEU: cmpRes = (rdDataA >= rdDataB);
      default: cmpRes = 1'b0;
    endcase
  end

  assign accNext = ctl.accumEn ? (acc | (XLEN'(cmpRes) << idx)) : acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAQ    <= '0;
      srcBQ    <= '0;
      predRegQ <= '0;
      vecAQ    <= 1'b0;
      vecBQ    <= 1'b0;
      cmpQ     <= '0;
      acc      <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      brValid  <= 1'b0;
      brTaken  <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (ctl.load) begin
        srcAQ    <= srcA;
        srcBQ    <= srcB;
        predRegQ <= predReg;
        vecAQ    <= ctl.vecA;
        vecBQ    <= ctl.vecB;
        cmpQ     <= cmpSel;
        acc      <= '0;
      end else begin
        acc <= accNext;
      end
      wrEn    <= ctl.lastPred;
      brValid <= ctl.lastBr;
      done    <= ctl.lastPred | ctl.lastBr;
      if (ctl.lastPred) begin
        wrAddr <= predRegQ;
        wrData <= accNext;
      end
      if (ctl.lastBr) brTaken <= cmpRes;
    end
  end

endmodule

// File: rtl/vec_cmp_pred.sv
module vec_cmp_pred
  import vec_cmp_pred_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int REGW = $clog2(NREG),
  localparam int VLW  = $clog2(XLEN + 1),
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [REGW-1:0] srcA,
  input  logic [VLW-1:0]  lenA,
  input  logic [REGW-1:0] srcB,
  input  logic [VLW-1:0]  lenB,
  input  logic [VLW-1:0]  vl,
  input  logic [2:0]      cmpSel,
  input  logic [REGW-1:0] predReg,
  output logic [REGW-1:0] rdAddrA,
  input  logic [XLEN-1:0] rdDataA,
  output logic [REGW-1:0] rdAddrB,
  input  logic [XLEN-1:0] rdDataB,
  output logic            busy,
  output logic            wrEn,
  output logic [REGW-1:0] wrAddr,
  output logic [XLEN-1:0] wrData,
  output logic            brValid,
  output logic            brTaken,
  output logic            done
);

  ctrl_t           ctl;
  logic [IDXW-1:0] idx;

  vec_cmp_pred_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .lenA (lenA),
    .lenB (lenB),
    .vl   (vl),
    .ctl  (ctl),
    .idx  (idx),
    .busy (busy)
  );

  vec_cmp_pred_dpath #(.XLEN(XLEN), .NREG(NREG)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .idx    (idx),
    .srcA   (srcA),
    .srcB   (srcB),
    .cmpSel (cmpSel),
    .predReg(predReg),
    .rdAddrA(rdAddrA),
    .rdDataA(rdDataA),
    .rdAddrB(rdAddrB),
    .rdDataB(rdDataB),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .brValid(brValid),
    .brTaken(brTaken),
    .done   (done)
  );

endmodule

// File: rtl/vec_cmp_pred_chk.sv
module vec_cmp_pred_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic wrEn,
  input logic brValid,
  input logic done
);

  // R5
  write_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> done);

  // R6
  branch_excludes_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrEn, brValid}));

  // R6
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (wrEn || brValid));

  // R8
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R8
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind vec_cmp_pred vec_cmp_pred_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .wrEn   (wrEn),
  .brValid(brValid),
  .done   (done)
);

// File: tb/vec_cmp_pred_test.sv
module vec_cmp_pred_test;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  srcA = '0, srcB = '0, predReg = '0;
  logic [5:0]  lenA = '0, lenB = '0, vl = '0;
  logic [2:0]  cmpSel = '0;
  logic [4:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic        busy, wrEn, brValid, brTaken, done;

  logic [31:0] rf [NREG];
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  assign rdDataA = rf[rdAddrA];
  assign rdDataB = rf[rdAddrB];

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_cmp_pred uut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcA(srcA), .lenA(lenA), .srcB(srcB), .lenB(lenB), .vl(vl),
    .cmpSel(cmpSel), .predReg(predReg),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .busy(busy), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .brValid(brValid), .brTaken(brTaken), .done(done)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
      finishRun();
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic refCmp(input logic [2:0] sel, input logic [31:0] a, input logic [31:0] b);
    case (sel)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return $signed(a) < $signed(b);
      3'd3: return $signed(a) >= $signed(b);
      3'd4: return a < b;
      3'd5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int clampVl(input logic [5:0] v);
    return (int'(v) > XLEN) ? XLEN : int'(v);
  endfunction

  function automatic logic [31:0] refPred();
    logic [31:0] p = '0;
    for (int i = 0; i < clampVl(vl); i++) begin
      logic [4:0] ia = srcA + ((lenA > 1) ? 5'(i) : 5'd0);
      logic [4:0] ib = srcB + ((lenB > 1) ? 5'(i) : 5'd0);
      p[i] = refCmp(cmpSel, rf[ia], rf[ib]);
    end
    return p;
  endfunction

  // Runs one operation with the current inputs; optionally pulses a stray start while busy.
  task automatic runOp(input string tag, input bit stray);
    bit isBr = !(lenA > 1) && !(lenB > 1);
    logic [31:0] expPred = refPred();
    logic expTaken = refCmp(cmpSel, rf[srcA], rf[srcB]);
    logic [4:0] expAddr = predReg;
    int expLat = isBr ? 1 : ((clampVl(vl) > 1) ? clampVl(vl) : 1);
    int cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      @(negedge clk);
      cnt++;
      if (stray && cnt == 1) begin
        check("R8 busy after start", busy, 1);
        start = 1'b1; srcA = srcA + 5'd3; vl = 6'd2; cmpSel = ~cmpSel; predReg = ~predReg;
      end
      if (stray && cnt == 2) start = 1'b0;
      if (done || cnt > 60) break;
    end
    check({tag, " R7 latency"}, cnt, expLat);
    if (isBr) begin
      check({tag, " R6 no write"}, wrEn, 0);
      check({tag, " R6 brValid"}, brValid, 1);
      check({tag, " R6 brTaken R4"}, brTaken, expTaken);
    end else begin
      check({tag, " R5 wrEn"}, wrEn, 1);
      check({tag, " R5 wrAddr"}, wrAddr, expAddr);
      check({tag, " R3 R2 R1 wrData"}, wrData, expPred);
      check({tag, " R5 no branch"}, brValid, 0);
    end
    @(negedge clk);
    check({tag, " R5 done single"}, done, 0);
    if (stray) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check("R8 stray start no second done", done, 0);
      end
    end
  endtask

  task automatic fillRf(input int span);
    for (int r = 0; r < NREG; r++)
      rf[r] = (span == 0) ? $urandom() : ($urandom_range(span) - span / 2);
  endtask

  task automatic setOp(input logic [4:0] a, input logic [5:0] la, input logic [4:0] b,
                       input logic [5:0] lb, input logic [5:0] v, input logic [2:0] c,
                       input logic [4:0] p);
    srcA = a; lenA = la; srcB = b; lenB = lb; vl = v; cmpSel = c; predReg = p;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fillRf(6);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 wrEn", wrEn, 0);
    check("R9 brValid", brValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 each compare code on a vector-vector op
    for (int c = 0; c < 8; c++) begin
      fillRf(4);
      setOp(5'd2, 6'd8, 5'd12, 6'd8, 6'd8, 3'(c), 5'd7);
      runOp("R4 code", 1'b0);
    end
    // R7 VL of zero writes zero
    setOp(5'd1, 6'd4, 5'd9, 6'd4, 6'd0, 3'd1, 5'd3);
    runOp("R7 vl0", 1'b0);
    // R3 full width and clamp above XLEN
    fillRf(2);
    setOp(5'd0, 6'd32, 5'd0, 6'd1, 6'd32, 3'd3, 5'd30);
    runOp("R3 vl32", 1'b0);
    setOp(5'd5, 6'd1, 5'd4, 6'd40, 6'd45, 3'd5, 5'd31);
    runOp("R3 vl45", 1'b0);
    // R2 wrap past last register
    fillRf(0);
    setOp(5'd29, 6'd6, 5'd30, 6'd6, 6'd6, 3'd4, 5'd1);
    runOp("R2 wrap", 1'b0);
    // R1 length 1 and 0 are scalar: branch
    setOp(5'd3, 6'd1, 5'd3, 6'd0, 6'd10, 3'd0, 5'd2);
    runOp("R1 len1 len0", 1'b0);
    setOp(5'd3, 6'd1, 5'd4, 6'd1, 6'd10, 3'd2, 5'd2);
    runOp("R6 branch", 1'b0);
    // R8 stray start while busy
    fillRf(4);
    setOp(5'd8, 6'd5, 5'd16, 6'd1, 6'd5, 3'd2, 5'd9);
    runOp("R8 stray", 1'b1);

    // random mix
    for (int n = 0; n < 120; n++) begin
      fillRf(($urandom_range(3) == 0) ? 0 : 6);
      setOp(5'($urandom()), 6'($urandom_range(3) == 0 ? $urandom_range(1) : $urandom_range(40)),
            5'($urandom()), 6'($urandom_range(3) == 0 ? $urandom_range(1) : $urandom_range(40)),
            6'($urandom_range(40)), 3'($urandom()), 5'($urandom()));
      runOp("rand", 1'b0);
    end
    finishRun();
  end

endmodule